// File: doc/BRIEF.md
# Debounced Pushbutton Event Counter

This block cleans up a bank of raw mechanical pushbutton inputs and uses two of them to drive an event counter. Every button first passes through a one-stage input register. It then goes into its own hysteresis filter. The filter holds its output at the old level until the input has shown the new level for `DEBOUNCE_CYCLES` clock cycles in a row. If the input goes back to the current output level before the window completes, the stability run starts again from zero.

The filtered levels of the two command buttons go to a rising-edge detector. One button's press adds one to the count and the other button's press clears it. A press counts once however long the button is held, and contact bounce on a press or a release adds nothing. When both command edges fall in the same cycle, the clear wins. The count wraps from its all-ones value to zero. All filtered levels leave the block so that other logic can use the remaining buttons.

The block runs on one clock with a synchronous active-high reset. Reset zeroes the count and sets every filtered level to the released value 0.

Top module: `pb_event_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `count` is 0 and every bit of `btn_level` is 0.
- R2: A bit of `btn_level` takes a new raw level exactly `DEBOUNCE_CYCLES`+1 clock edges after that level is applied to `btn_raw`: one edge for the input register and `DEBOUNCE_CYCLES` for the filter.
- R3: A raw excursion that lasts fewer than `DEBOUNCE_CYCLES` cycles before returning restarts the stability run. It leaves `btn_level` unchanged and does not touch `count`.
- R4: A press of button `INC_SEL` (default bit 0) raises `count` by exactly one, one edge after its filtered level rises, however long the button is held.
- R5: Releasing any button, with or without contact bounce, never changes `count`.
- R6: A press of button `CLR_SEL` (default bit 1) sets `count` to 0 one edge after its filtered level rises.
- R7: When the filtered increment and clear levels rise in the same cycle, `count` becomes 0.
- R8: An increment from the all-ones value of the `CNT_W`-bit count gives 0.
- R9: Each of the `NUM_BTN` channels is filtered independently. A press on a button other than `INC_SEL` and `CLR_SEL` shows on its own `btn_level` bit only and leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | NUM_BTN | Raw pushbutton levels, 1 = pressed |
| count | output | CNT_W | Event counter value |
| btn_level | output | NUM_BTN | Debounced button levels, 1 = pressed |

## Verification
The increment and the clear can act in the same cycle. The bench provokes this by raising both command buttons at the same clock edge while the count is not zero, so that both filters complete their windows together. It judges the result by reading `count` after the edge where both rises take effect and expecting zero. The bench also follows a single press through its exact latency edge by edge. It drives bounce trains shorter than the window on both the press and the release, and steps the counter across its wrap point.

// File: rtl/pb_cnt_pkg.sv
package pb_cnt_pkg;

    localparam int DEF_NUM_BTN   = 5;
    localparam int DEF_CNT_W     = 16;
    localparam int DEF_DB_CYCLES = 16;

    // Command events derived from the debounced buttons
    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_evt_t;

    // Counter operation chosen for one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_CLEAR = 2'd2
    } cnt_op_t;

    // Width of a run counter able to hold 0 .. n-1
    function automatic int run_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Clear has priority over increment
    function automatic cnt_op_t pick_op(input cnt_evt_t e);
        if (e.clr)      return OP_CLEAR;
        else if (e.inc) return OP_INC;
        else            return OP_HOLD;
    endfunction

endpackage

// File: rtl/pb_debounce.sv
module pb_debounce
    import pb_cnt_pkg::*;
#(
    parameter int DB_CYCLES = DEF_DB_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int RW = run_width(DB_CYCLES);
    localparam logic [RW-1:0] RUN_LAST = RW'(DB_CYCLES - 1);

    logic          samp_q;
    logic          level_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q  <= 1'b0;
            level_q <= 1'b0;
            run_q   <= '0;
        end else begin
            samp_q <= raw;
            if (samp_q != level_q) begin
                if (run_q == RUN_LAST) begin
                    level_q <= samp_q;
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign level = level_q;

    // The filtered level only moves toward the sampled input
    AST_DB_TOWARD_INPUT: assert property (@(posedge clk) disable iff (rst)
        (level_q != $past(level_q)) |-> ($past(samp_q) == level_q)); // R2

    // An input matching the output leaves the output alone next cycle
    AST_DB_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (samp_q == level_q) |=> (level_q == $past(level_q))); // R3

endmodule

// File: rtl/pb_rise.sv
module pb_rise
    import pb_cnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     inc_lvl,
    input  logic     clr_lvl,
    output cnt_evt_t evt
);
    cnt_evt_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q.inc <= inc_lvl;
            prev_q.clr <= clr_lvl;
        end
    end

    always_comb begin
        evt.inc = inc_lvl & ~prev_q.inc;
        evt.clr = clr_lvl & ~prev_q.clr;
    end

    // A rising edge never fires on two consecutive cycles
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt.inc |=> !evt.inc); // R4

    // A falling or steady level produces no edge
    AST_RISE_NOT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !inc_lvl |-> !evt.inc); // R5

endmodule

// File: rtl/pb_counter.sv
module pb_counter
    import pb_cnt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_evt_t         evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    cnt_op_t          op;

    always_comb op = pick_op(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: count_q <= '0;
                OP_INC:   count_q <= count_q + 1'b1;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        evt.clr |=> (count_q == '0)); // R6

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt.clr && evt.inc) |=> (count_q == '0)); // R7

    AST_INC_ONE: assert property (@(posedge clk) disable iff (rst)
        (evt.inc && !evt.clr && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1)); // R4

    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (evt.inc && !evt.clr && count_q == CNT_MAX) |=> (count_q == '0)); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!evt.inc && !evt.clr) |=> $stable(count_q)); // R5

endmodule

// File: rtl/pb_event_counter.sv
module pb_event_counter
    import pb_cnt_pkg::*;
#(
    parameter int NUM_BTN         = DEF_NUM_BTN,
    parameter int CNT_W           = DEF_CNT_W,
    parameter int DEBOUNCE_CYCLES = DEF_DB_CYCLES,
    parameter int INC_SEL         = 0,
    parameter int CLR_SEL         = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BTN-1:0] btn_raw,
    output logic [CNT_W-1:0]   count,
    output logic [NUM_BTN-1:0] btn_level
);
    logic [NUM_BTN-1:0] lvl;
    cnt_evt_t           evt;

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_chan
        pb_debounce #(.DB_CYCLES(DEBOUNCE_CYCLES)) u_db (
            .clk   (clk),
            .rst   (rst),
            .raw   (btn_raw[g]),
            .level (lvl[g])
        );
    end

    pb_rise u_rise (
        .clk     (clk),
        .rst     (rst),
        .inc_lvl (lvl[INC_SEL]),
        .clr_lvl (lvl[CLR_SEL]),
        .evt     (evt)
    );

    pb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .count (count)
    );

    assign btn_level = lvl;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (count == '0 && btn_level == '0)); // R1

endmodule

// File: tb/tb_pb_event_counter.sv
module tb_pb_event_counter;

    localparam int NB  = 5;
    localparam int CW  = 8;
    localparam int DB  = 4;
    localparam int INC = 0;
    localparam int CLR = 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [NB-1:0] btn_raw;
    logic [CW-1:0] count;
    logic [NB-1:0] btn_level;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] exp_cnt;

    always #10 clk = ~clk;

    pb_event_counter #(
        .NUM_BTN(NB), .CNT_W(CW), .DEBOUNCE_CYCLES(DB),
        .INC_SEL(INC), .CLR_SEL(CLR)
    ) dut (
        .clk(clk), .rst(rst), .btn_raw(btn_raw),
        .count(count), .btn_level(btn_level)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tap(input int b);
        btn_raw[b] = 1'b1;
        step(DB + 3);
        btn_raw[b] = 1'b0;
        step(DB + 3);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        btn_raw = '0;
        step(3);
        chk("R1 count in reset", 32'(count), 0);
        chk("R1 levels in reset", 32'(btn_level), 0);
        rst = 1'b0;
        step(1);
        chk("R1 count after reset", 32'(count), 0);
        chk("R1 levels after reset", 32'(btn_level), 0);
        exp_cnt = '0;
    endtask

    task automatic t_latency_hold;
        btn_raw[INC] = 1'b1;
        step(DB);
        chk("R2 level before window", 32'(btn_level[INC]), 0);
        step(1);
        chk("R2 level at window end", 32'(btn_level[INC]), 1);
        chk("R4 count not yet", 32'(count), 32'(exp_cnt));
        step(1);
        exp_cnt = exp_cnt + 1'b1;
        chk("R4 count after press", 32'(count), 32'(exp_cnt));
        step(30);
        chk("R4 long hold counts once", 32'(count), 32'(exp_cnt));
        btn_raw[INC] = 1'b0;
        step(DB);
        chk("R2 release level before window", 32'(btn_level[INC]), 1);
        step(1);
        chk("R2 release level at window end", 32'(btn_level[INC]), 0);
        step(3);
        chk("R5 release keeps count", 32'(count), 32'(exp_cnt));
    endtask

    task automatic t_bounce_press;
        for (int k = 0; k < 3; k++) begin
            btn_raw[INC] = 1'b1;
            step(DB - 1);
            btn_raw[INC] = 1'b0;
            step(1);
            chk("R3 short pulse level", 32'(btn_level[INC]), 0);
        end
        step(DB + 2);
        chk("R3 short pulses no count", 32'(count), 32'(exp_cnt));
        btn_raw[INC] = 1'b1;
        step(DB + 3);
        exp_cnt = exp_cnt + 1'b1;
        chk("R4 settled press after bounce", 32'(count), 32'(exp_cnt));
    endtask

    task automatic t_bounce_release;
        for (int k = 0; k < 3; k++) begin
            btn_raw[INC] = 1'b0;
            step(DB - 1);
            btn_raw[INC] = 1'b1;
            step(1);
            chk("R3 release bounce level held", 32'(btn_level[INC]), 1);
        end
        btn_raw[INC] = 1'b0;
        step(DB + 3);
        chk("R5 bounced release level", 32'(btn_level[INC]), 0);
        chk("R5 bounced release count", 32'(count), 32'(exp_cnt));
    endtask

    task automatic t_clear;
        chk("R6 precondition nonzero", 32'(count != 0), 1);
        btn_raw[CLR] = 1'b1;
        step(DB + 3);
        exp_cnt = '0;
        chk("R6 clear press", 32'(count), 0);
        btn_raw[CLR] = 1'b0;
        step(DB + 3);
        chk("R6 clear release", 32'(count), 0);
    endtask

    task automatic t_same_cycle;
        tap(INC);
        tap(INC);
        exp_cnt = 2;
        chk("R7 precondition", 32'(count), 2);
        btn_raw[INC] = 1'b1;
        btn_raw[CLR] = 1'b1;
        step(DB + 2);
        exp_cnt = '0;
        chk("R7 clear wins", 32'(count), 0);
        btn_raw = '0;
        step(DB + 3);
        chk("R7 release after both", 32'(count), 0);
    endtask

    task automatic t_wrap;
        for (int k = 0; k < (1 << CW) - 1; k++) tap(INC);
        chk("R8 at all ones", 32'(count), (1 << CW) - 1);
        tap(INC);
        exp_cnt = '0;
        chk("R8 wrap to zero", 32'(count), 0);
    endtask

    task automatic t_indep;
        tap(INC);
        exp_cnt = 1;
        btn_raw[4] = 1'b1;
        step(DB + 2);
        chk("R9 own level only", 32'(btn_level), 32'h10);
        chk("R9 other button no count", 32'(count), 1);
        btn_raw[2] = 1'b1;
        btn_raw[3] = 1'b1;
        step(DB + 2);
        chk("R9 three levels", 32'(btn_level), 32'h1C);
        btn_raw = '0;
        step(DB + 3);
        chk("R9 all released", 32'(btn_level), 0);
        chk("R9 count unchanged", 32'(count), 1);
    endtask

    initial begin
        t_reset();
        t_latency_hold();
        t_bounce_press();
        t_bounce_release();
        t_clear();
        t_same_cycle();
        t_wrap();
        t_indep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule